// File: doc/BRIEF.md
# Edge Delay and Deglitch Filter

This block conditions a single-bit asynchronous input using a programmable timebase. The input is brought into the clock domain through a two-stage synchronizer and edge-detected. A retriggerable one-shot sets the timing. It is built from a presettable down-counter, which is reloaded on every synchronized input edge and which counts on a prescaled clock enable. The block can hold back the rising edge only, hold back the falling edge only, or act as a symmetric low-pass filter that swallows short pulses and passes long ones delayed.

The delay count N is the bitwise inverse of the active-low preset bus, so N runs from 1 to 255. The all-ones preset code (N = 0) is illegal. While it is applied, the block raises an error flag and freezes its output. The counter advances once every D system clocks, and D is chosen from 1, 16, 256 or 4096. A qualifying change on the input therefore reaches the output after about N·D clocks plus a fixed pipeline latency.

Top module: `edge_delay_filter`

## Requirements
- R1: Edges that are not delayed (falling edges in mode 01, rising edges in mode 10) pass through two synchronizer flops and one output register. With `din` changed before rising clock edge 1, `dout` shows the new value after edge 3.
- R2: In mode 01 (`mode_sel` = 2'b01, rising-edge delay) with `div_sel` = 2'b00 and N = ~`preset_n`, a low-to-high change of `din` applied before clock edge 1 appears on `dout` after edge N+4.
- R3: In mode 10 (falling-edge delay) with `div_sel` = 2'b00, a high-to-low change of `din` appears on `dout` after edge N+4, and rising changes follow R1.
- R4: In filter mode with `div_sel` = 2'b00, a `din` pulse lasting W clocks never reaches `dout` when W ≤ N+1. When W ≥ N+2, it is reproduced with width W and its leading edge appears after edge N+4. The same holds for low-going pulses when `dout` is high.
- R5: `div_sel` codes 00, 01, 10 and 11 select a count step of D = 1, 16, 256 and 4096 clocks. In mode 01, a delayed rising edge appears after an edge count between (N−1)·D+5 and N·D+4 inclusive.
- R6: Every synchronized edge of `din` reloads the counter. In mode 01, a rising edge followed by a short low dip and a second rise produces a rising `dout` N+4 edges after the second rise, and `dout` stays low before that.
- R7: When `preset_n` is all ones, `preset_err` is 1 in the same cycle and `dout` keeps its value. When a legal code returns, a pending undelayed edge reaches `dout` at the next clock edge.
- R8: While `rst_n` is low, `dout` is 0, and the counter and synchronizer are cleared.
- R9: `mode_sel` codes 2'b00 and 2'b11 both select the filter behaviour of R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| din | input | 1 | Asynchronous input to be conditioned |
| preset_n | input | CNT_W (8) | Active-low delay count, N = ~preset_n |
| div_sel | input | 2 | Count step select: 1, 16, 256 or 4096 clocks |
| mode_sel | input | 2 | 01 rising delay, 10 falling delay, 00/11 filter |
| dout | output | 1 | Conditioned output |
| preset_err | output | 1 | High while the preset code is all ones |

## Verification
The assertions check on every cycle that undelayed edges in the two delay modes take effect at the next register update. They also check that the output freezes under an illegal preset, that in filter mode the output moves only on a counter expiry that no new edge cancels, and that a reload always clears a pending expiry. They also check that the prescaler enable is never asserted two cycles in a row when the step is larger than one.

Only the bench scenarios can show the exact delay values. These are the N+4 latency swept over many N, the suppress-or-pass threshold at W = N+1 versus N+2 together with the reproduced pulse width, the delay windows for the larger prescale steps, the restart after a dip, and the aliasing of both filter codes.

// File: rtl/edf_pkg.sv
package edf_pkg;

  typedef enum logic [1:0] {
    EDF_LPF_A    = 2'b00,
    EDF_DLY_RISE = 2'b01,
    EDF_DLY_FALL = 2'b10,
    EDF_LPF_B    = 2'b11
  } edf_mode_e;

  // Decision taken each cycle from the synchronized level and the output
  typedef struct packed {
    logic need_delay;  // output differs from level in a direction that waits for the timer
    logic pass_now;    // output differs in a direction that is forwarded at once
  } edf_qual_t;

  function automatic edf_qual_t edf_qualify(edf_mode_e mode, logic lvl, logic cur);
    edf_qual_t q;
    case (mode)
      EDF_DLY_RISE: begin
        q.need_delay = lvl & ~cur;
        q.pass_now   = ~lvl & cur;
      end
      EDF_DLY_FALL: begin
        q.need_delay = ~lvl & cur;
        q.pass_now   = lvl & ~cur;
      end
      default: begin
        q.need_delay = lvl ^ cur;
        q.pass_now   = 1'b0;
      end
    endcase
    return q;
  endfunction

endpackage

// File: rtl/edf_sync.sv
module edf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level = chain_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;

endmodule

// File: rtl/edf_prescale.sv
module edf_prescale #(
  parameter  int STAGES = 3,
  parameter  int STEP   = 4,
  localparam int W      = STAGES * STEP,
  localparam int SW     = $clog2(STAGES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] sel,
  output logic          tick
);

  logic [W-1:0]    cnt_q, cnt_d;
  logic [STAGES:0] tap;

  assign tap[0] = 1'b1;
  generate
    for (genvar s = 1; s <= STAGES; s++) begin : g_tap
      assign tap[s] = &cnt_q[s*STEP-1:0];
    end
  endgenerate

  assign tick = tap[sel];

  always_comb begin
    cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // with a step above one the enable can never hold for two cycles
  p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != '0 && tick) |=> (!tick || !$stable(sel)));

endmodule

// File: rtl/edf_oneshot.sv
module edf_oneshot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         expire,
  output logic         busy
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         armed_q, armed_d;

  assign expire = armed_q && (cnt_q == '0);
  assign busy   = armed_q;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (load) begin
      cnt_d   = load_val;
      armed_d = 1'b1;
    end else if (expire) begin
      armed_d = 1'b0;
    end else if (tick && cnt_q != '0) begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  p_single_expire_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load) |=> !expire);

endmodule

// File: rtl/edge_delay_filter.sv
module edge_delay_filter
  import edf_pkg::*;
#(
  parameter  int CNT_W       = 8,
  parameter  int SYNC_STAGES = 2,
  parameter  int PRE_STAGES  = 3,
  parameter  int PRE_STEP    = 4,
  localparam int SEL_W       = $clog2(PRE_STAGES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [CNT_W-1:0] preset_n,
  input  logic [SEL_W-1:0] div_sel,
  input  logic [1:0]       mode_sel,
  output logic             dout,
  output logic             preset_err
);

  logic      lvl, edge_r, edge_f;
  logic      tick, expire, busy, load;
  logic      out_q, out_d;
  edf_mode_e mode;
  edf_qual_t qual;

  edf_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .din(din),
    .level(lvl), .rise(edge_r), .fall(edge_f)
  );

  edf_prescale #(.STAGES(PRE_STAGES), .STEP(PRE_STEP)) pre_i (
    .clk(clk), .rst_n(rst_n), .sel(div_sel), .tick(tick)
  );

  edf_oneshot #(.W(CNT_W)) shot_i (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(~preset_n),
    .tick(tick), .expire(expire), .busy(busy)
  );

  assign mode       = edf_mode_e'(mode_sel);
  assign qual       = edf_qualify(mode, lvl, out_q);
  assign preset_err = &preset_n;
  assign load       = !preset_err && (edge_r || edge_f || (qual.need_delay && !busy));

  always_comb begin
    out_d = out_q;
    if (!preset_err) begin
      if (qual.pass_now)
        out_d = lvl;
      else if (expire && !load && qual.need_delay)
        out_d = lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign dout = out_q;

  p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    preset_err |=> $stable(out_q));

  p_rise_mode_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == EDF_DLY_RISE && !preset_err && !lvl) |=> !out_q);

  p_fall_mode_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == EDF_DLY_FALL && !preset_err && lvl) |=> out_q);

  p_lpf_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == EDF_LPF_A || mode == EDF_LPF_B) && !(expire && !load)) |=> $stable(out_q));

  p_reload_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !expire);

endmodule

// File: tb/edge_delay_filter_tb.sv
module edge_delay_filter_tb_top;

  logic       clk;
  logic       rst_n;
  logic       din;
  logic [7:0] preset_n;
  logic [1:0] div_sel;
  logic [1:0] mode_sel;
  logic       dout;
  logic       preset_err;

  int checks;
  int fails;
  bit done;

  edge_delay_filter dut_i (
    .clk(clk), .rst_n(rst_n), .din(din), .preset_n(preset_n),
    .div_sel(div_sel), .mode_sel(mode_sel), .dout(dout), .preset_err(preset_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive a new level and count rising edges until dout follows
  task automatic meas(input logic v, input int maxc, output int lat);
    din = v;
    lat = maxc + 1;
    for (int i = 1; i <= maxc; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (dout == v) begin
        lat = i;
        break;
      end
    end
  endtask

  // pulse of width w away from level base, observing dout for t edges
  task automatic pulse(input logic base, input int w, input int t,
                       output int first, output int width);
    first = 0;
    width = 0;
    din   = ~base;
    for (int i = 1; i <= t; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (i == w) din = base;
      if (dout != base) begin
        if (first == 0) first = i;
        width++;
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int lat, first, width, n, d, lo, hi;
    checks = 0; fails = 0; done = 0;
    rst_n = 1'b0; din = 1'b0; preset_n = ~8'd5; div_sel = 2'b00; mode_sel = 2'b01;
    idle(3);
    check(dout == 1'b0, "R8 dout in reset", int'(dout), 0);
    check(preset_err == 1'b0, "R8 err in reset", int'(preset_err), 0);
    din = 1'b1;
    idle(4);
    check(dout == 1'b0, "R8 dout held by reset", int'(dout), 0);
    din = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(2);

    // R2 rising delay sweep, R1 pass latency of falls
    mode_sel = 2'b01;
    for (int k = 1; k <= 41; k++) begin
      n = (k == 41) ? 255 : k;
      preset_n = ~8'(n);
      idle(2);
      meas(1'b1, n + 20, lat);
      check(lat == n + 4, "R2 rise delay", lat, n + 4);
      meas(1'b0, 20, lat);
      check(lat == 3, "R1 fall pass", lat, 3);
    end

    // R3 falling delay sweep, R1 pass latency of rises
    mode_sel = 2'b10;
    for (int k = 1; k <= 40; k++) begin
      preset_n = ~8'(k);
      idle(2);
      meas(1'b1, 20, lat);
      check(lat == 3, "R1 rise pass", lat, 3);
      meas(1'b0, k + 20, lat);
      check(lat == k + 4, "R3 fall delay", lat, k + 4);
    end

    // R4 filter threshold and width, with both filter codes (R9)
    for (int c = 0; c < 2; c++) begin
      mode_sel = (c == 0) ? 2'b00 : 2'b11;
      for (int j = 0; j < 3; j++) begin
        n = (j == 0) ? 1 : (j == 1) ? 3 : 6;
        preset_n = ~8'(n);
        idle(n + 8);
        for (int w = 1; w <= n + 3; w++) begin
          pulse(1'b0, w, n + w + 12, first, width);
          if (w >= n + 2) begin
            check(first == n + 4, c == 0 ? "R4 pulse lead" : "R9 pulse lead", first, n + 4);
            check(width == w, c == 0 ? "R4 pulse width" : "R9 pulse width", width, w);
          end else begin
            check(width == 0, c == 0 ? "R4 pulse suppressed" : "R9 pulse suppressed", width, 0);
          end
          idle(n + 8);
        end
      end
    end

    // R4 low-going pulses on a high output
    mode_sel = 2'b00;
    preset_n = ~8'd3;
    idle(4);
    meas(1'b1, 40, lat);
    check(lat == 7, "R4 filter rise", lat, 7);
    idle(12);
    pulse(1'b1, 2, 20, first, width);
    check(width == 0, "R4 low dip suppressed", width, 0);
    idle(12);
    pulse(1'b1, 6, 24, first, width);
    check(width == 6, "R4 low pulse width", width, 6);
    check(first == 7, "R4 low pulse lead", first, 7);
    idle(12);
    meas(1'b0, 40, lat);
    idle(4);

    // R5 prescale windows
    mode_sel = 2'b01;
    for (int k = 0; k < 4; k++) begin
      div_sel = (k < 2) ? 2'b01 : (k == 2) ? 2'b10 : 2'b11;
      n = (k == 0) ? 2 : (k == 1) ? 3 : (k == 2) ? 2 : 1;
      d = (div_sel == 2'b01) ? 16 : (div_sel == 2'b10) ? 256 : 4096;
      preset_n = ~8'(n);
      lo = (n - 1) * d + 5;
      hi = n * d + 4;
      idle(3);
      meas(1'b1, hi + 20, lat);
      check(lat >= lo && lat <= hi, "R5 prescaled delay", lat, lo);
      meas(1'b0, 20, lat);
      check(lat == 3, "R1 fall pass prescaled", lat, 3);
    end
    div_sel = 2'b00;

    // R6 retrigger after a dip
    preset_n = ~8'd10;
    idle(3);
    din = 1'b1;
    idle(5);
    check(dout == 1'b0, "R6 still low before dip", int'(dout), 0);
    din = 1'b0;
    idle(2);
    check(dout == 1'b0, "R6 low during dip", int'(dout), 0);
    meas(1'b1, 40, lat);
    check(lat == 14, "R6 delay from last rise", lat, 14);

    // R7 illegal preset freezes output
    preset_n = 8'hFF;
    #1;
    check(preset_err == 1'b1, "R7 err flag", int'(preset_err), 1);
    din = 1'b0;
    idle(20);
    check(dout == 1'b1, "R7 dout frozen", int'(dout), 1);
    preset_n = ~8'd4;
    #1;
    check(preset_err == 1'b0, "R7 err clear", int'(preset_err), 0);
    @(posedge clk);
    @(negedge clk);
    check(dout == 1'b0, "R7 release pass", int'(dout), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule